// File: doc/BRIEF.md
# Address-Sequence Nonvolatile Command Detector

This block sits beside a byte-wide static memory. It watches the active-low chip enable, write enable and output enable strobes together with the word address. Among ordinary reads it looks for a hidden chain of six addresses. The first five addresses form a common prefix. The sixth address picks the command. One sixth address asks for a copy of the volatile array into the shadow nonvolatile array (store). Another asks for a copy back the other way (recall). Any other access partway through the chain discards the progress made so far.

When a command is accepted, the block emits a one-cycle command pulse. It then raises a busy flag that blocks all normal memory traffic while it steps through timed phases. A store runs an erase phase followed by a program phase. A recall runs a single copy phase. Each phase length is a parameter counted in clock cycles. The strobes are sampled on the block clock, and an optional synchroniser depth is chosen by parameter.

Top module: `nvseq_detector`

## Requirements
- R1: After the five prefix reads (word addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, in that order), a sixth read of 0x0FC0 makes `store_pulse` high for exactly one cycle. The pulse appears in the cycle after the clock edge that samples that read, and `busy` rises in the same cycle.
- R2: After the same prefix, a sixth read of 0x0C63 makes `recall_pulse` high for one cycle, with `busy` rising alongside it. The two pulses are never high together.
- R3: A read of any address other than the expected one, at any position in the chain, aborts it. Finishing the remaining addresses afterwards produces no pulse and no busy.
- R4: A chip-enable falling edge with `we_n` low (a write) aborts the chain at any position. A write never counts as a step, even when its address is the expected one.
- R5: The level of `oe_n` has no effect on whether a read counts as a step.
- R6: A step is taken only on a falling edge of `ce_n` (high in one sampled cycle, low in the next) while `we_n` is high. Changing the address while `ce_n` stays low advances nothing.
- R7: An aborting read whose address is 0x0E38 restarts the chain at step one instead of clearing it.
- R8: After a store starts, `phase` reads 1 (erase) for ERASE_CYC cycles and then 2 (program) for PROG_CYC cycles. `busy` then falls and `phase` returns to 0 (idle).
- R9: After a recall starts, `phase` reads 3 (copy) for COPY_CYC cycles. `busy` then falls and `phase` returns to 0.
- R10: While `busy` is high, every strobe edge is ignored and the chain is held cleared. A prefix issued during busy does not carry over past the end of busy.
- R11: Reset, including reset during a busy period, gives `busy` = 0, `phase` = 0 and both pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low (does not affect detection) |
| we_n | input | 1 | Write enable strobe, active low |
| addr | input | ADDR_W (15) | Word address |
| store_pulse | output | 1 | One-cycle pulse when a store command is accepted |
| recall_pulse | output | 1 | One-cycle pulse when a recall command is accepted |
| busy | output | 1 | High during the nonvolatile cycle; normal I/O is held off |
| phase | output | 2 | 0 idle, 1 erase, 2 program, 3 copy |

## Verification
The assertions assume the following about the inputs:
- The strobes and the address are already synchronous to `clk` when SYNC_STAGES is 0.
- Each chip-enable low period is held for at least one sampling edge.

The bench keeps within these rules. It changes every input only on the falling clock edge, and each access holds `ce_n` low for a full cycle and then high for at least one cycle. Given those inputs, the properties check the following:
- A rising busy is always caused by a command pulse.
- No pulse can come from a cycle that was already busy.
- A program phase is entered only from an erase phase.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ERASE = 2'd1,
      PH_PROG  = 2'd2,
      PH_COPY  = 2'd3
   } nv_phase_e;

   // number of shared prefix steps before the selecting step
   localparam int PREFIX_LEN = 5;

   localparam logic [15:0] SEL_STORE  = 16'h0FC0;
   localparam logic [15:0] SEL_RECALL = 16'h0C63;

   function automatic logic [15:0] prefix_key(input int idx);
      logic [15:0] k;
      case (idx)
         0:       k = 16'h0E38;
         1:       k = 16'h31C7;
         2:       k = 16'h03E0;
         3:       k = 16'h3C1F;
         default: k = 16'h303F;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/nvseq_strobe.sv
module nvseq_strobe #(
   parameter int ADDR_W      = 15,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              step_valid,
   output logic              step_write,
   output logic [ADDR_W-1:0] step_addr
);

   logic              ce_s;
   logic              we_s;
   logic [ADDR_W-1:0] a_s;
   logic              ce_prev;

   initial begin
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("nvseq_strobe: SYNC_STAGES must be 0..4");
   end

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign ce_s = ce_n;
         assign we_s = we_n;
         assign a_s  = addr;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] ce_p;
         logic [SYNC_STAGES-1:0] we_p;
         logic [ADDR_W-1:0]      a_p [SYNC_STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ce_p <= '1;
               we_p <= '1;
               for (int i = 0; i < SYNC_STAGES; i++) a_p[i] <= '0;
            end else begin
               ce_p[0] <= ce_n;
               we_p[0] <= we_n;
               a_p[0]  <= addr;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  ce_p[i] <= ce_p[i-1];
                  we_p[i] <= we_p[i-1];
                  a_p[i]  <= a_p[i-1];
               end
            end
         end

         assign ce_s = ce_p[SYNC_STAGES-1];
         assign we_s = we_p[SYNC_STAGES-1];
         assign a_s  = a_p[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_prev <= 1'b1;
      else        ce_prev <= ce_s;
   end

   assign step_valid = ce_prev & ~ce_s;
   assign step_write = ~we_s;
   assign step_addr  = a_s;

endmodule

// File: rtl/nvseq_chain.sv
module nvseq_chain
   import nvseq_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              step_valid,
   input  logic              step_write,
   input  logic [ADDR_W-1:0] step_addr,
   output logic              fire_store,
   output logic              fire_recall
);

   localparam int STEP_W = $clog2(PREFIX_LEN + 1);

   logic [STEP_W-1:0] step_q, step_d;

   initial begin
      assert (ADDR_W >= 14 && ADDR_W <= 16)
         else $error("nvseq_chain: ADDR_W must cover the key addresses (14..16)");
   end

   function automatic logic key_hit(input logic [ADDR_W-1:0] a, input logic [15:0] k);
      return a == ADDR_W'(k);
   endfunction

   always_comb begin
      step_d      = step_q;
      fire_store  = 1'b0;
      fire_recall = 1'b0;
      if (!enable) begin
         step_d = '0;
      end else if (step_valid) begin
         if (step_write) begin
            step_d = '0;
         end else if (int'(step_q) < PREFIX_LEN) begin
            if (key_hit(step_addr, prefix_key(int'(step_q))))
               step_d = step_q + 1'b1;
            else if (key_hit(step_addr, prefix_key(0)))
               step_d = STEP_W'(1);
            else
               step_d = '0;
         end else begin
            step_d = '0;
            if (key_hit(step_addr, SEL_STORE))
               fire_store = 1'b1;
            else if (key_hit(step_addr, SEL_RECALL))
               fire_recall = 1'b1;
            else if (key_hit(step_addr, prefix_key(0)))
               step_d = STEP_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= '0;
      else        step_q <= step_d;
   end

   // R3: the step index never runs past the selecting step
   p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(step_q) <= PREFIX_LEN);

   // R4: a write edge always leaves the chain cleared
   p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && step_write) |=> step_q == '0);

   // R10: the chain is held cleared while disabled
   p_hold_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> step_q == '0);

endmodule

// File: rtl/nvseq_phase.sv
module nvseq_phase
   import nvseq_pkg::*;
#(
   parameter int ERASE_CYC = 8,
   parameter int PROG_CYC  = 16,
   parameter int COPY_CYC  = 12
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_store,
   input  logic      start_recall,
   output nv_phase_e phase,
   output logic      busy,
   output logic      store_pulse,
   output logic      recall_pulse
);

   localparam int MAX_A = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int MAX_C = (MAX_A > COPY_CYC) ? MAX_A : COPY_CYC;
   localparam int CNT_W = $clog2(MAX_C + 1);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (ERASE_CYC >= 1 && PROG_CYC >= 1 && COPY_CYC >= 1)
         else $error("nvseq_phase: every phase needs at least one cycle");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= PH_IDLE;
         cnt_q        <= '0;
         store_pulse  <= 1'b0;
         recall_pulse <= 1'b0;
      end else begin
         store_pulse  <= 1'b0;
         recall_pulse <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start_store) begin
                  phase       <= PH_ERASE;
                  cnt_q       <= CNT_W'(ERASE_CYC - 1);
                  store_pulse <= 1'b1;
               end else if (start_recall) begin
                  phase        <= PH_COPY;
                  cnt_q        <= CNT_W'(COPY_CYC - 1);
                  recall_pulse <= 1'b1;
               end
            end
            PH_ERASE: begin
               if (cnt_q == '0) begin
                  phase <= PH_PROG;
                  cnt_q <= CNT_W'(PROG_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (cnt_q == '0) phase <= PH_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
         endcase
      end
   end

   assign busy = (phase != PH_IDLE);

   // R1: busy only rises together with a command pulse
   p_rise_has_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (store_pulse || recall_pulse));

   // R2: the two command pulses are exclusive
   p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(store_pulse && recall_pulse));

   // R1: the store pulse lasts one cycle
   p_store_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      store_pulse |=> !store_pulse);

   // R8: a store opens with the erase phase
   p_store_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      store_pulse |-> phase == PH_ERASE);

   // R8: program is entered only from erase
   p_prog_after_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PROG && $past(phase) != PH_PROG) |-> $past(phase) == PH_ERASE);

   // R9: a recall opens with the copy phase
   p_recall_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      recall_pulse |-> phase == PH_COPY);

   // R10: no command is accepted out of a busy cycle
   p_no_fire_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> !(store_pulse || recall_pulse));

endmodule

// File: rtl/nvseq_detector.sv
module nvseq_detector
   import nvseq_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int SYNC_STAGES = 0,
   parameter int ERASE_CYC   = 8,
   parameter int PROG_CYC    = 16,
   parameter int COPY_CYC    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              store_pulse,
   output logic              recall_pulse,
   output logic              busy,
   output logic [1:0]        phase
);

   logic              step_valid;
   logic              step_write;
   logic [ADDR_W-1:0] step_addr;
   logic              fire_store;
   logic              fire_recall;
   nv_phase_e         phase_e;
   logic              unused_oe;

   // detection never depends on the output enable level
   assign unused_oe = oe_n;

   nvseq_strobe #(
      .ADDR_W     (ADDR_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .we_n      (we_n),
      .addr      (addr),
      .step_valid(step_valid),
      .step_write(step_write),
      .step_addr (step_addr)
   );

   nvseq_chain #(
      .ADDR_W(ADDR_W)
   ) u_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (~busy),
      .step_valid (step_valid),
      .step_write (step_write),
      .step_addr  (step_addr),
      .fire_store (fire_store),
      .fire_recall(fire_recall)
   );

   nvseq_phase #(
      .ERASE_CYC(ERASE_CYC),
      .PROG_CYC (PROG_CYC),
      .COPY_CYC (COPY_CYC)
   ) u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_store (fire_store),
      .start_recall(fire_recall),
      .phase       (phase_e),
      .busy        (busy),
      .store_pulse (store_pulse),
      .recall_pulse(recall_pulse)
   );

   assign phase = phase_e;

   // R11: reset leaves the block idle
   p_idle_after_reset_r11: assert property (@(posedge clk)
      $rose(rst_n) |-> (!busy && !store_pulse && !recall_pulse));

endmodule

// File: tb/nvseq_detector_bench.sv
`timescale 1ns/1ps
module nvseq_detector_bench;

   localparam int E = 5;
   localparam int P = 7;
   localparam int C = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1;
   logic        oe_n = 1'b1;
   logic        we_n = 1'b1;
   logic [14:0] addr = '0;
   logic        store_pulse, recall_pulse, busy;
   logic [1:0]  phase;

   int checks = 0;
   int errors = 0;
   bit sp, rp, bz;

   always #2 clk = ~clk;

   nvseq_detector #(
      .ADDR_W(15), .SYNC_STAGES(0),
      .ERASE_CYC(E), .PROG_CYC(P), .COPY_CYC(C)
   ) u_nvseq_detector (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .store_pulse(store_pulse), .recall_pulse(recall_pulse),
      .busy(busy), .phase(phase)
   );

   function automatic logic [14:0] key(input int i);
      case (i)
         0: return 15'h0E38;
         1: return 15'h31C7;
         2: return 15'h03E0;
         3: return 15'h3C1F;
         4: return 15'h303F;
         5: return 15'h0FC0;
         default: return 15'h0C63;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one access: ce falls at a negedge, outputs sampled one cycle later
   task automatic step(input logic [14:0] a, input bit wr, input bit oe_low);
      @(negedge clk);
      addr = a; we_n = ~wr; oe_n = ~oe_low; ce_n = 1'b0;
      @(negedge clk);
      sp = store_pulse; rp = recall_pulse; bz = busy;
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic prefix(input int n, input bit oe_low);
      for (int i = 0; i < n; i++) step(key(i), 1'b0, oe_low);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && phase == 0 && !store_pulse && !recall_pulse, "R11 reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 + R8: store and its phases
      prefix(5, 1'b0);
      chk(!sp && !bz, "R1 no pulse on prefix", sp, 0);
      step(key(5), 1'b0, 1'b0);
      chk(sp && !rp, "R1 store pulse", sp, 1);
      chk(bz, "R1 busy with pulse", bz, 1);
      for (int i = 0; i < E + P; i++) begin
         chk(phase == ((i < E) ? 2'd1 : 2'd2) && busy, "R8 phase", phase, (i < E) ? 1 : 2);
         if (i == 1) chk(!store_pulse, "R1 single cycle", store_pulse, 0);
         @(negedge clk);
      end
      chk(!busy && phase == 0, "R8 end of store", phase, 0);

      // R2 + R9: recall and its phase
      prefix(5, 1'b0);
      step(key(6), 1'b0, 1'b0);
      chk(rp && !sp && bz, "R2 recall pulse", rp, 1);
      for (int i = 0; i < C; i++) begin
         chk(phase == 2'd3 && busy, "R9 copy phase", phase, 3);
         @(negedge clk);
      end
      chk(!busy && phase == 0, "R9 end of recall", phase, 0);

      // R3: wrong address at every position
      for (int pos = 0; pos < 6; pos++) begin
         bit any = 0;
         for (int i = 0; i < 6; i++) begin
            step((i == pos) ? 15'h1234 : key(i), 1'b0, 1'b0);
            any |= sp | rp | bz;
         end
         chk(!any && !busy, $sformatf("R3 abort at %0d", pos), any, 0);
      end

      // R4: write at every position, even to the expected address
      for (int pos = 0; pos < 6; pos++) begin
         bit any = 0;
         for (int i = 0; i < 6; i++) begin
            step(key(i), i == pos, 1'b0);
            any |= sp | rp | bz;
         end
         chk(!any && !busy, $sformatf("R4 write abort at %0d", pos), any, 0);
      end

      // R5: output enable asserted throughout still counts
      prefix(5, 1'b1);
      step(key(5), 1'b0, 1'b1);
      chk(sp, "R5 oe low store", sp, 1);
      wait_idle();
      for (int i = 0; i < 6; i++) step(key(i == 5 ? 6 : i), 1'b0, i[0]);
      chk(rp, "R5 oe mixed recall", rp, 1);
      wait_idle();

      // R6: address change while ce stays low is not a step
      prefix(4, 1'b0);
      @(negedge clk);
      addr = key(4); ce_n = 1'b0;
      @(negedge clk);
      addr = key(5);
      repeat (3) begin
         @(negedge clk);
         chk(!store_pulse && !busy, "R6 held ce no step", store_pulse, 0);
      end
      ce_n = 1'b1;
      step(key(5), 1'b0, 1'b0);
      chk(sp, "R6 new edge counts", sp, 1);
      wait_idle();

      // R7: abort on first key restarts the chain
      step(key(0), 1'b0, 1'b0);
      step(key(1), 1'b0, 1'b0);
      prefix(5, 1'b0);
      step(key(5), 1'b0, 1'b0);
      chk(sp, "R7 restart mid-chain", sp, 1);
      wait_idle();
      prefix(5, 1'b0);
      step(key(0), 1'b0, 1'b0);
      for (int i = 1; i < 6; i++) step(key(i), 1'b0, 1'b0);
      chk(sp, "R7 restart at select step", sp, 1);
      wait_idle();

      // R10: prefix during busy is ignored
      prefix(5, 1'b0);
      step(key(5), 1'b0, 1'b0);
      chk(sp, "R10 setup store", sp, 1);
      begin
         bit any = 0;
         prefix(5, 1'b0);
         any = sp | rp;
         chk(!any && busy, "R10 still busy, no pulse", any, 0);
      end
      wait_idle();
      step(key(5), 1'b0, 1'b0);
      chk(!sp && !bz, "R10 prefix not kept", sp, 0);

      // R11: reset during busy
      prefix(5, 1'b0);
      step(key(6), 1'b0, 1'b0);
      chk(bz, "R11 setup recall", bz, 1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy && phase == 0 && !recall_pulse, "R11 reset mid-busy", phase, 0);
      rst_n = 1'b1;
      @(negedge clk);
      prefix(5, 1'b0);
      step(key(6), 1'b0, 1'b0);
      chk(rp, "R11 works after reset", rp, 1);
      wait_idle();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule